// File: doc/BRIEF.md
# Systolic Dot-Product Grid Cell

This block is one cell of a two-dimensional systolic grid used to test rays against spheres. A sphere-center vector enters on one side of the cell, and a ray-direction vector enters on the side at right angles to it. Each vector is held in the cell and handed on, unchanged, to the neighbouring cell on the far side. Each vector has its own advance strobe, so a column of spheres and a row of rays can be stepped independently.

From the two held vectors the cell computes their signed fixed-point dot product in a short pipeline and presents the result on a wider output that feeds the next layer of the grid. Components use the Q7.10 format: 1 sign bit, 7 integer bits and 10 fraction bits. Each component product is Q15.20. The 36-bit sum of the three products is narrowed to the 32-bit output by dropping its four least significant bits.

A string parameter controls how the sphere vector leaves the cell. In the registered setting it leaves from the held copy. In the combinational setting it is wired straight through, which suits the last cell of a grid or a single-cell grid. The dot-product path uses the internal held copy in both settings.

Top module: `dot_grid_cell`

## Requirements
- R1: When `rst_ni` goes low, all held vectors and all pipeline registers clear to zero at once, without waiting for a clock edge. All outputs then read zero.
- R2: With `sph_adv_i` high at a rising edge, that edge captures the sphere inputs. In the registered setting (`SPH_PASS_REG == "yes"`) they appear on `sph_*_o` after that edge.
- R3: While `sph_adv_i` is low, the held sphere vector keeps its value whatever the sphere inputs do.
- R4: With `ray_adv_i` high at a rising edge, that edge captures the ray inputs, and they appear on `ray_*_o` after that edge.
- R5: While `ray_adv_i` is low, the held ray vector and `ray_*_o` keep their values whatever the ray inputs do.
- R6: The two strobes act independently. Advancing one vector leaves the other held vector unchanged, and the dot product is then formed from the new vector and the retained one.
- R7: `dot_o` is bits [35:4] of the 36-bit two's-complement sum of sx*rx + sy*ry + sz*rz, where each operand is an 18-bit signed value.
- R8: If vectors are captured at edge N, `dot_o` shows their product after edge N+2 and not before. The pipeline runs every cycle, so `dot_o` stays stable while both held vectors are stable.
- R9: With `SPH_PASS_REG` set to anything other than "yes", `sph_*_o` equals `sph_*_i` in the same cycle. The dot-product timing is still that of R8.
- R10: The 36-bit sum wraps with no saturation. With all six components at -131072, `dot_o` reads -1073741824.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sph_adv_i | input | 1 | Sphere advance strobe |
| ray_adv_i | input | 1 | Ray advance strobe |
| sph_x_i | input | COMP_W | Sphere x component in |
| sph_y_i | input | COMP_W | Sphere y component in |
| sph_z_i | input | COMP_W | Sphere z component in |
| sph_x_o | output | COMP_W | Sphere x component to neighbour |
| sph_y_o | output | COMP_W | Sphere y component to neighbour |
| sph_z_o | output | COMP_W | Sphere z component to neighbour |
| ray_x_i | input | COMP_W | Ray x component in |
| ray_y_i | input | COMP_W | Ray y component in |
| ray_z_i | input | COMP_W | Ray z component in |
| ray_x_o | output | COMP_W | Ray x component to neighbour |
| ray_y_o | output | COMP_W | Ray y component to neighbour |
| ray_z_o | output | COMP_W | Ray z component to neighbour |
| dot_o | output | OUT_W | Dot product, 36-bit sum bits [35:4] |

## Verification
The bench streams five corner values, covering both extremes, zero and odd mid-range values, through all six components, giving 15625 vector pairs at one pair per cycle. Each dot product is checked exactly three capture stages later, so an off-by-one pipeline shows up as the neighbouring pair's result. A design that saturates, rounds, or takes the wrong 32-bit slice disagrees at the extremes, and the all-minimum case catches a sum kept wider than 36 bits. Idle and single-strobe phases catch a cell that advances on the wrong strobe or fails to hold. A second instance in the combinational setting must follow its sphere inputs in the same cycle while keeping the same dot-product timing.

// File: rtl/dot_cell_pkg.sv
package dot_cell_pkg;
  localparam int AXES = 3;

  typedef enum logic [1:0] {
    AX_X = 2'd0,
    AX_Y = 2'd1,
    AX_Z = 2'd2
  } axis_e;

  function automatic int drop_bits(input int in_w, input int out_w);
    return in_w - out_w;
  endfunction
endpackage

// File: rtl/vec_hold.sv
module vec_hold #(
  parameter int W        = 18,
  parameter int N        = 3,
  parameter bit COMB_OUT = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic [N-1:0][W-1:0] d_i,
  output logic [N-1:0][W-1:0] held_o,
  output logic [N-1:0][W-1:0] pass_o
);
  logic [N-1:0][W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    held_q <= '0;
    else if (adv_i) held_q <= d_i;
  end

  assign held_o = held_q;

  generate
    if (COMB_OUT) begin : g_comb
      assign pass_o = d_i;
    end else begin : g_reg
      assign pass_o = held_q;
    end
  endgenerate

  a_r3_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(held_o));

  a_r2_r4_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> held_o == $past(d_i));
endmodule

// File: rtl/smul_reg.sv
module smul_reg #(
  parameter int W = 18,
  localparam int PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] p_o
);
  logic signed [PW-1:0] a_ext, b_ext;
  logic signed [PW-1:0] prod;

  // Sign-extend to full width; true product always fits in PW bits
  assign a_ext = {{W{a_i[W-1]}}, a_i};
  assign b_ext = {{W{b_i[W-1]}}, b_i};
  assign prod  = a_ext * b_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_o <= '0;
    else         p_o <= prod;
  end

  a_r7_zero_factor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |=> p_o == '0);
endmodule

// File: rtl/add3_reg.sv
module add3_reg #(
  parameter int IN_W  = 36,
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  a_i,
  input  logic [IN_W-1:0]  b_i,
  input  logic [IN_W-1:0]  c_i,
  output logic [OUT_W-1:0] y_o
);
  logic [IN_W-1:0] sum_q;

  // Modular add: identical for two's-complement operands, wraps at IN_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else         sum_q <= a_i + b_i + c_i;
  end

  assign y_o = sum_q[IN_W-1 -: OUT_W];

  a_r8_stable_in_stable_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(a_i) && $stable(b_i) && $stable(c_i)) |=> $stable(y_o));
endmodule

// File: rtl/dot_grid_cell.sv
module dot_grid_cell
  import dot_cell_pkg::*;
#(
  parameter int    COMP_W       = 18,
  parameter int    OUT_W        = 32,
  parameter string SPH_PASS_REG = "yes"
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sph_adv_i,
  input  logic              ray_adv_i,
  input  logic [COMP_W-1:0] sph_x_i,
  input  logic [COMP_W-1:0] sph_y_i,
  input  logic [COMP_W-1:0] sph_z_i,
  output logic [COMP_W-1:0] sph_x_o,
  output logic [COMP_W-1:0] sph_y_o,
  output logic [COMP_W-1:0] sph_z_o,
  input  logic [COMP_W-1:0] ray_x_i,
  input  logic [COMP_W-1:0] ray_y_i,
  input  logic [COMP_W-1:0] ray_z_i,
  output logic [COMP_W-1:0] ray_x_o,
  output logic [COMP_W-1:0] ray_y_o,
  output logic [COMP_W-1:0] ray_z_o,
  output logic [OUT_W-1:0]  dot_o
);
  localparam int PROD_W   = 2 * COMP_W;
  localparam int DROP     = drop_bits(PROD_W, OUT_W);
  localparam bit SPH_COMB = (SPH_PASS_REG != "yes");

  logic [AXES-1:0][COMP_W-1:0] sph_d, sph_held, sph_pass;
  logic [AXES-1:0][COMP_W-1:0] ray_d, ray_held, ray_pass;
  logic [AXES-1:0][PROD_W-1:0] prod;

  assign sph_d[AX_X] = sph_x_i;
  assign sph_d[AX_Y] = sph_y_i;
  assign sph_d[AX_Z] = sph_z_i;
  assign ray_d[AX_X] = ray_x_i;
  assign ray_d[AX_Y] = ray_y_i;
  assign ray_d[AX_Z] = ray_z_i;

  // Sphere copy is always held for the multipliers; the parameter only picks the forward path
  vec_hold #(.W(COMP_W), .N(AXES), .COMB_OUT(SPH_COMB)) u_sph (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (sph_adv_i),
    .d_i   (sph_d),
    .held_o(sph_held),
    .pass_o(sph_pass)
  );

  vec_hold #(.W(COMP_W), .N(AXES), .COMB_OUT(1'b0)) u_ray (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (ray_adv_i),
    .d_i   (ray_d),
    .held_o(ray_held),
    .pass_o(ray_pass)
  );

  assign sph_x_o = sph_pass[AX_X];
  assign sph_y_o = sph_pass[AX_Y];
  assign sph_z_o = sph_pass[AX_Z];
  assign ray_x_o = ray_pass[AX_X];
  assign ray_y_o = ray_pass[AX_Y];
  assign ray_z_o = ray_pass[AX_Z];

  generate
    for (genvar g = 0; g < AXES; g++) begin : g_mul
      smul_reg #(.W(COMP_W)) u_mul (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .a_i   (sph_held[g]),
        .b_i   (ray_held[g]),
        .p_o   (prod[g])
      );
    end
  endgenerate

  add3_reg #(.IN_W(PROD_W), .OUT_W(OUT_W)) u_sum (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .a_i   (prod[AX_X]),
    .b_i   (prod[AX_Y]),
    .c_i   (prod[AX_Z]),
    .y_o   (dot_o)
  );

  logic sph_zero, ray_zero;
  assign sph_zero = (sph_held == '0);
  assign ray_zero = (ray_held == '0);

  initial begin
    a_r7_width_plan: assert (DROP >= 0);
  end

  a_r8_zero_operand_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sph_zero, 2) || $past(ray_zero, 2)) |-> dot_o == '0);

  a_r6_ray_strobe_leaves_sphere: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ray_adv_i && !sph_adv_i) |=> $stable(sph_held));
endmodule

// File: tb/dot_grid_cell_test.sv
module dot_grid_cell_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sph_adv = 1'b0, ray_adv = 1'b0;
  logic [17:0] sx, sy, sz, rx, ry, rz;
  logic [17:0] a_sx_o, a_sy_o, a_sz_o, a_rx_o, a_ry_o, a_rz_o;
  logic [17:0] b_sx_o, b_sy_o, b_sz_o, b_rx_o, b_ry_o, b_rz_o;
  logic [31:0] a_dot, b_dot;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dot_grid_cell #(.SPH_PASS_REG("yes")) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sph_adv_i(sph_adv), .ray_adv_i(ray_adv),
    .sph_x_i(sx), .sph_y_i(sy), .sph_z_i(sz),
    .sph_x_o(a_sx_o), .sph_y_o(a_sy_o), .sph_z_o(a_sz_o),
    .ray_x_i(rx), .ray_y_i(ry), .ray_z_i(rz),
    .ray_x_o(a_rx_o), .ray_y_o(a_ry_o), .ray_z_o(a_rz_o),
    .dot_o(a_dot));

  dot_grid_cell #(.SPH_PASS_REG("no")) uut_comb (
    .clk_i(clk), .rst_ni(rst_ni), .sph_adv_i(sph_adv), .ray_adv_i(ray_adv),
    .sph_x_i(sx), .sph_y_i(sy), .sph_z_i(sz),
    .sph_x_o(b_sx_o), .sph_y_o(b_sy_o), .sph_z_o(b_sz_o),
    .ray_x_i(rx), .ray_y_i(ry), .ray_z_i(rz),
    .ray_x_o(b_rx_o), .ray_y_o(b_ry_o), .ray_z_o(b_rz_o),
    .dot_o(b_dot));

  function automatic logic [31:0] f_dot(input int ax, ay, az, bx, by, bz);
    longint s;
    logic [63:0] u;
    s = longint'(ax) * bx + longint'(ay) * by + longint'(az) * bz;
    u = s;
    return u[35:4];
  endfunction

  function automatic logic [53:0] pk(input int x, y, z);
    logic [17:0] px, py, pz;
    px = x[17:0]; py = y[17:0]; pz = z[17:0];
    return {pz, py, px};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int ax, ay, az, bx, by, bz, input logic sa, ra);
    sx = ax[17:0]; sy = ay[17:0]; sz = az[17:0];
    rx = bx[17:0]; ry = by[17:0]; rz = bz[17:0];
    sph_adv = sa; ray_adv = ra;
  endtask

  task automatic chk_all_zero(input string tag);
    chk({a_sx_o, a_sy_o, a_sz_o, a_rx_o, a_ry_o, a_rz_o} == '0, {tag, " uut vectors"},
        longint'({a_sx_o, a_sy_o, a_sz_o}), 0);
    chk(a_dot == '0, {tag, " uut dot"}, longint'($signed(a_dot)), 0);
    chk({b_rx_o, b_ry_o, b_rz_o} == '0 && b_dot == '0, {tag, " uut_comb"},
        longint'($signed(b_dot)), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int vals[5] = '{-131072, -4097, 0, 3, 131071};
    logic [31:0] exp_q[4];
    logic [53:0] ps_q[4], pr_q[4];
    int it;
    logic [31:0] e_ab;

    // R1: reset holds everything at zero despite active strobes
    drive(1000, -5, 77, 9, 9, -9, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk_all_zero("R1 during reset");
    rst_ni = 1'b1;

    // Streamed sweep: R2, R4, R7, R8, R9
    it = 0;
    for (int i0 = 0; i0 < 5; i0++)
      for (int i1 = 0; i1 < 5; i1++)
        for (int i2 = 0; i2 < 5; i2++)
          for (int i3 = 0; i3 < 5; i3++)
            for (int i4 = 0; i4 < 5; i4++)
              for (int i5 = 0; i5 < 5; i5++) begin
                @(negedge clk);
                if (it >= 1) begin
                  chk({a_sz_o, a_sy_o, a_sx_o} == ps_q[(it-1)%4], "R2 sphere pass",
                      longint'({a_sz_o, a_sy_o, a_sx_o}), longint'(ps_q[(it-1)%4]));
                  chk({a_rz_o, a_ry_o, a_rx_o} == pr_q[(it-1)%4], "R4 ray pass",
                      longint'({a_rz_o, a_ry_o, a_rx_o}), longint'(pr_q[(it-1)%4]));
                end
                if (it >= 3) begin
                  chk(a_dot == exp_q[(it-3)%4], "R7 R8 dot value and latency",
                      longint'($signed(a_dot)), longint'($signed(exp_q[(it-3)%4])));
                  chk(b_dot == exp_q[(it-3)%4], "R9 comb setting dot latency",
                      longint'($signed(b_dot)), longint'($signed(exp_q[(it-3)%4])));
                end
                drive(vals[i0], vals[i1], vals[i2], vals[i3], vals[i4], vals[i5], 1'b1, 1'b1);
                exp_q[it%4] = f_dot(vals[i0], vals[i1], vals[i2], vals[i3], vals[i4], vals[i5]);
                ps_q[it%4]  = pk(vals[i0], vals[i1], vals[i2]);
                pr_q[it%4]  = pk(vals[i3], vals[i4], vals[i5]);
                #1;
                chk({b_sz_o, b_sy_o, b_sx_o} == ps_q[it%4], "R9 comb sphere follows input",
                    longint'({b_sz_o, b_sy_o, b_sx_o}), longint'(ps_q[it%4]));
                it++;
              end

    // Hold: R3, R5, R8 stability
    @(negedge clk);
    drive(1000, -2000, 300, -50, 7000, -123, 1'b1, 1'b1);
    @(negedge clk);
    drive(11, 22, 33, 44, 55, 66, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk({a_sz_o, a_sy_o, a_sx_o} == pk(1000, -2000, 300), "R3 sphere held while idle",
        longint'({a_sz_o, a_sy_o, a_sx_o}), longint'(pk(1000, -2000, 300)));
    chk({a_rz_o, a_ry_o, a_rx_o} == pk(-50, 7000, -123), "R5 ray held while idle",
        longint'({a_rz_o, a_ry_o, a_rx_o}), longint'(pk(-50, 7000, -123)));
    chk(a_dot == f_dot(1000, -2000, 300, -50, 7000, -123), "R8 dot stable on held vectors",
        longint'($signed(a_dot)), longint'($signed(f_dot(1000, -2000, 300, -50, 7000, -123))));
    chk({b_sz_o, b_sy_o, b_sx_o} == pk(11, 22, 33), "R9 comb sphere tracks idle input",
        longint'({b_sz_o, b_sy_o, b_sx_o}), longint'(pk(11, 22, 33)));

    // Independent strobes: R6
    drive(-999, -999, -999, 4, 5, 6, 1'b0, 1'b1);
    @(negedge clk);
    drive(-999, -999, -999, 4, 5, 6, 1'b0, 1'b0);
    chk({a_sz_o, a_sy_o, a_sx_o} == pk(1000, -2000, 300), "R6 sphere kept on ray strobe",
        longint'({a_sz_o, a_sy_o, a_sx_o}), longint'(pk(1000, -2000, 300)));
    chk({a_rz_o, a_ry_o, a_rx_o} == pk(4, 5, 6), "R6 ray advanced alone",
        longint'({a_rz_o, a_ry_o, a_rx_o}), longint'(pk(4, 5, 6)));
    repeat (2) @(negedge clk);
    e_ab = f_dot(1000, -2000, 300, 4, 5, 6);
    chk(a_dot == e_ab, "R6 dot of kept sphere and new ray",
        longint'($signed(a_dot)), longint'($signed(e_ab)));

    // Exact latency and wrap: R8, R10
    drive(-131072, -131072, -131072, -131072, -131072, -131072, 1'b1, 1'b1);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    chk(a_dot == e_ab, "R8 old dot after capture edge", longint'($signed(a_dot)), longint'($signed(e_ab)));
    @(negedge clk);
    chk(a_dot == e_ab, "R8 old dot after second edge", longint'($signed(a_dot)), longint'($signed(e_ab)));
    @(negedge clk);
    chk($signed(a_dot) == -32'sd1073741824, "R10 wrapped sum",
        longint'($signed(a_dot)), -1073741824);
    chk(a_dot == f_dot(-131072, -131072, -131072, -131072, -131072, -131072), "R10 wrap vs model",
        longint'($signed(a_dot)), -1073741824);

    // Asynchronous reset mid-cycle: R1
    #2 rst_ni = 1'b0;
    #1 chk_all_zero("R1 async reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule